// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block moves a group of 32-bit words between a register file and memory in a single operation. A one-cycle start pulse supplies four things: a bit mask that selects the registers taking part, a base byte address, a direction (load or store) and one of four addressing modes. A writeback flag comes with them. From that point the block issues one word access per cycle over a request/ready handshake. With each access it presents the index of the register involved. For a store it forwards that register's read data to memory. For a load it raises the register-file write enable when the memory accepts the beat.

The mask is walked from bit 0 upward, so the addresses always ascend and the highest-numbered selected register always lands at the highest address. The mode only chooses where the covered region sits relative to the base. When the transfer ends the block pulses `done`. If writeback was requested, it also strobes out the base moved by four bytes per transferred register.

Top module: `blk_xfer_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `mem_req` and `base_we` are low.
- R2: A `start` pulse seen while idle with a non-empty mask raises `busy` and `mem_req` in the next cycle. The first beat uses the lowest selected register index and the lowest address of the region. With N selected registers and `mode` encoded as 0 (increment-after), 1 (increment-before), 2 (decrement-after) and 3 (decrement-before), the lowest address is base, base+4, base-4N+4 and base-4N respectively, modulo 2^32.
- R3: After each accepted beat (`mem_req` and `mem_ready` high) that is not the last, the next beat follows in the next cycle. Its address is 4 higher and its register index is the next higher set mask bit.
- R4: While `mem_req` is high and `mem_ready` is low, the request, its address and its register index hold steady.
- R5: During a store, `mem_we` is high and `mem_wdata` equals `reg_rdata`, and `reg_we` stays low. During a load, `mem_we` is low, `reg_we` equals `mem_ready`, and `reg_wdata` equals `mem_rdata`.
- R6: In the cycle after the last beat is accepted, `busy` and `mem_req` are low and `done` is high for exactly one cycle.
- R7: With the writeback flag set, `base_we` is high together with `done`, and `base_out` is base+4N for modes 0 and 1 or base-4N for modes 2 and 3. With the flag clear, `base_we` stays low and `base_out` equals the base.
- R8: A start with an all-zero mask produces `done` in the next cycle with no memory request, no `busy` and no `base_we`, and `base_out` equals the base.
- R9: A `start` pulse and any change of the command inputs while `busy` is high have no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command pulse, taken only while idle |
| reg_mask | input | 16 | Selected registers, bit i for register i |
| base_in | input | 32 | Base byte address |
| is_load | input | 1 | 1 for memory to registers, 0 for registers to memory |
| mode | input | 2 | Addressing mode, encoded as in R2 |
| wb_en | input | 1 | Request an updated base at the end |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the current beat |
| mem_rdata | input | 32 | Load data for the current beat |
| reg_idx | output | 4 | Register index of the current beat |
| reg_rdata | input | 32 | Register-file read data at `reg_idx` |
| reg_we | output | 1 | Register-file write enable |
| reg_wdata | output | 32 | Register-file write data |
| base_out | output | 32 | Updated base value, valid with `done` |
| base_we | output | 1 | Base writeback strobe |

## Verification
The hardest situation to bring about is a new command arriving while an old one is still stalled mid-transfer. The stimulus therefore holds `mem_ready` low on a share of cycles and, during such a transfer, pulses `start` every cycle while it keeps changing the mask, base and mode. Decrement modes are also driven with bases near zero so that the region start wraps around the address space. A full 16-register mask exercises the widest count the region arithmetic has to handle.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    XM_INC_AFTER  = 2'd0,
    XM_INC_BEFORE = 2'd1,
    XM_DEC_AFTER  = 2'd2,
    XM_DEC_BEFORE = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/blk_xfer_popcnt.sv
module blk_xfer_popcnt #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/blk_xfer_lowbit.sv
module blk_xfer_lowbit #(
  parameter int W  = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/blk_xfer_addr.sv
module blk_xfer_addr
  import blk_xfer_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 5,
  parameter int BYTES = 4
) (
  input  logic [AW-1:0] base,
  input  xfer_mode_e    mode,
  input  logic [CW-1:0] cnt,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] final_base
);
  logic [AW-1:0] span;
  logic [AW-1:0] step;

  assign step = AW'(BYTES);
  assign span = AW'(cnt) * step;

  always_comb begin
    unique case (mode)
      XM_INC_AFTER: begin
        first_addr = base;
        final_base = base + span;
      end
      XM_INC_BEFORE: begin
        first_addr = base + step;
        final_base = base + span;
      end
      XM_DEC_AFTER: begin
        first_addr = base - span + step;
        final_base = base - span;
      end
      default: begin
        first_addr = base - span;
        final_base = base - span;
      end
    endcase
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BYTES = 4,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0]   base_in,
  input  logic            is_load,
  input  logic [1:0]      mode,
  input  logic            wb_en,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IW-1:0]   reg_idx,
  input  logic [DW-1:0]   reg_rdata,
  output logic            reg_we,
  output logic [DW-1:0]   reg_wdata,
  output logic [AW-1:0]   base_out,
  output logic            base_we
);
  // command decode (start cycle)
  logic [CW-1:0] sel_cnt;
  logic [IW-1:0] first_idx;
  logic          first_found;
  logic [AW-1:0] first_addr;
  logic [AW-1:0] final_base;

  // transfer state
  logic            busy_q;
  logic            done_q;
  logic            base_we_q;
  logic            load_q;
  logic            wb_q;
  logic [NREG-1:0] pend_q;
  logic [AW-1:0]   addr_q;
  logic [IW-1:0]   idx_q;
  logic [AW-1:0]   final_q;
  logic [AW-1:0]   base_out_q;

  // next beat
  logic [IW-1:0] nxt_idx;
  logic          nxt_found;
  logic          beat_ok;

  blk_xfer_popcnt #(.W(NREG)) u_cnt (
    .vec (reg_mask),
    .cnt (sel_cnt)
  );

  blk_xfer_lowbit #(.W(NREG)) u_first (
    .vec   (reg_mask),
    .idx   (first_idx),
    .found (first_found)
  );

  blk_xfer_lowbit #(.W(NREG)) u_next (
    .vec   (pend_q),
    .idx   (nxt_idx),
    .found (nxt_found)
  );

  blk_xfer_addr #(.AW(AW), .CW(CW), .BYTES(BYTES)) u_addr (
    .base       (base_in),
    .mode       (xfer_mode_e'(mode)),
    .cnt        (sel_cnt),
    .first_addr (first_addr),
    .final_base (final_base)
  );

  assign beat_ok = busy_q & mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      base_we_q  <= 1'b0;
      load_q     <= 1'b0;
      wb_q       <= 1'b0;
      pend_q     <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      final_q    <= '0;
      base_out_q <= '0;
    end else begin
      done_q    <= 1'b0;
      base_we_q <= 1'b0;
      if (busy_q) begin
        if (beat_ok) begin
          if (nxt_found) begin
            addr_q <= addr_q + AW'(BYTES);
            idx_q  <= nxt_idx;
            pend_q <= pend_q & ~(NREG'(1) << nxt_idx);
          end else begin
            busy_q     <= 1'b0;
            done_q     <= 1'b1;
            base_we_q  <= wb_q;
            base_out_q <= final_q;
          end
        end
      end else if (start) begin
        load_q  <= is_load;
        wb_q    <= wb_en;
        final_q <= wb_en ? final_base : base_in;
        if (first_found) begin
          busy_q <= 1'b1;
          addr_q <= first_addr;
          idx_q  <= first_idx;
          pend_q <= reg_mask & ~(NREG'(1) << first_idx);
        end else begin
          done_q     <= 1'b1;
          base_out_q <= base_in;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_req   = busy_q;
  assign mem_we    = busy_q & ~load_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = reg_rdata;
  assign reg_idx   = idx_q;
  assign reg_we    = beat_ok & load_q;
  assign reg_wdata = mem_rdata;
  assign base_out  = base_out_q;
  assign base_we   = base_we_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int AW    = 32,
  parameter int IW    = 4,
  parameter int BYTES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [IW-1:0] reg_idx,
  input logic          reg_we,
  input logic          base_we
);
  p_req_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req && mem_ready)) |-> (mem_addr == $past(mem_addr) + AW'(BYTES)));

  p_idx_rises_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req && mem_ready)) |-> (reg_idx > $past(reg_idx)));

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(reg_idx)));

  p_one_dir_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && mem_we));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_end_gives_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_wb_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    base_we |-> done);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.AW(AW), .IW(IW), .BYTES(BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .reg_idx   (reg_idx),
  .reg_we    (reg_we),
  .base_we   (base_we)
);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [31:0] base_in = '0;
  logic        is_load = 1'b0;
  logic [1:0]  mode = '0;
  logic        wb_en = 1'b0;
  logic        mem_ready = 1'b0;
  logic        busy, done, mem_req, mem_we, reg_we, base_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, reg_rdata, reg_wdata, base_out;
  logic [3:0]  reg_idx;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string phase = "R2";

  always #5 clk = ~clk;

  // memory and register file models: pure functions of address / index
  assign mem_rdata = mem_addr ^ 32'h5A5A_0F0F;
  assign reg_rdata = {16'hC0DE, 12'h000, reg_idx};

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst(rst), .start(start), .reg_mask(reg_mask), .base_in(base_in),
    .is_load(is_load), .mode(mode), .wb_en(wb_en), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .reg_idx(reg_idx),
    .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .base_out(base_out), .base_we(base_we)
  );

  // ---------------- reference model ----------------
  logic [31:0] q_addr[$];
  int          q_idx[$];
  bit          m_busy, m_done, m_wbs, m_load, m_wb, m_first, m_stalled, m_rst_seen;
  logic [31:0] m_final, m_base_out;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_wbs = 0; m_first = 0; m_stalled = 0;
      m_rst_seen = 1;
      q_addr.delete(); q_idx.delete();
    end else begin
      m_rst_seen = 0;
      m_done = 0; m_wbs = 0;
      if (m_busy) begin
        if (mem_ready) begin
          void'(q_addr.pop_front()); void'(q_idx.pop_front());
          m_first = 0; m_stalled = 0;
          if (q_addr.size() == 0) begin
            m_busy = 0; m_done = 1; m_wbs = m_wb; m_base_out = m_final;
          end
        end else m_stalled = 1;
      end else if (start) begin
        int n;
        logic [31:0] lo;
        n = $countones(reg_mask);
        case (mode)
          2'd0: lo = base_in;
          2'd1: lo = base_in + 32'd4;
          2'd2: lo = base_in - 32'(4 * n) + 32'd4;
          default: lo = base_in - 32'(4 * n);
        endcase
        m_load = is_load; m_wb = wb_en;
        m_final = !wb_en ? base_in : (mode < 2 ? base_in + 32'(4 * n) : base_in - 32'(4 * n));
        for (int i = 0; i < 16; i++) begin
          if (reg_mask[i]) begin
            q_addr.push_back(lo);
            q_idx.push_back(i);
            lo = lo + 32'd4;
          end
        end
        if (n == 0) begin
          m_done = 1; m_base_out = base_in;
        end else begin
          m_busy = 1; m_first = 1; m_stalled = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, after inputs have been driven at the falling edge
  always @(negedge clk) begin
    #2;
    if (m_rst_seen) begin
      chk(busy == 0, "R1", "busy", 32'(busy), 0);
      chk(done == 0, "R1", "done", 32'(done), 0);
      chk(mem_req == 0, "R1", "mem_req", 32'(mem_req), 0);
      chk(base_we == 0, "R1", "base_we", 32'(base_we), 0);
    end else begin
      string btag, atag;
      btag = phase;
      atag = m_first ? "R2" : (m_stalled ? "R4" : "R3");
      chk(busy == m_busy, btag, "busy", 32'(busy), 32'(m_busy));
      chk(mem_req == m_busy, btag, "mem_req", 32'(mem_req), 32'(m_busy));
      chk(done == m_done, (phase == "R8") ? "R8" : "R6", "done", 32'(done), 32'(m_done));
      chk(base_we == m_wbs, (phase == "R8") ? "R8" : "R7", "base_we", 32'(base_we), 32'(m_wbs));
      if (m_done)
        chk(base_out == m_base_out, (phase == "R8") ? "R8" : "R7", "base_out", base_out, m_base_out);
      if (m_busy && q_addr.size() > 0) begin
        chk(mem_addr == q_addr[0], atag, "mem_addr", mem_addr, q_addr[0]);
        chk(reg_idx == 4'(q_idx[0]), atag, "reg_idx", 32'(reg_idx), 32'(q_idx[0]));
        chk(mem_we == !m_load, "R5", "mem_we", 32'(mem_we), 32'(!m_load));
        if (!m_load) begin
          chk(mem_wdata == {16'hC0DE, 12'h000, 4'(q_idx[0])}, "R5", "mem_wdata",
              mem_wdata, {16'hC0DE, 12'h000, 4'(q_idx[0])});
          chk(reg_we == 0, "R5", "reg_we(store)", 32'(reg_we), 0);
        end else begin
          chk(reg_we == mem_ready, "R5", "reg_we(load)", 32'(reg_we), 32'(mem_ready));
          if (mem_ready)
            chk(reg_wdata == (q_addr[0] ^ 32'h5A5A_0F0F), "R5", "reg_wdata",
                reg_wdata, q_addr[0] ^ 32'h5A5A_0F0F);
        end
      end else begin
        chk(reg_we == 0, "R5", "reg_we(idle)", 32'(reg_we), 0);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input logic [15:0] msk, input logic [31:0] b, input bit ld,
                      input logic [1:0] md, input bit wb, input int stall_pct, input bit poke);
    start = 1; reg_mask = msk; base_in = b; is_load = ld; mode = md; wb_en = wb;
    mem_ready = ($urandom_range(99) >= stall_pct);
    @(negedge clk);
    while (m_busy) begin
      mem_ready = ($urandom_range(99) >= stall_pct);
      // R9: scrambled command and repeated start while the transfer runs
      start    = poke;
      reg_mask = $urandom(); base_in = $urandom(); mode = 2'($urandom());
      is_load  = 1'($urandom()); wb_en = 1'($urandom());
      @(negedge clk);
    end
    start = 0; mem_ready = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R2";
    xfer(16'h01F0, 32'h0000_1000, 0, 2'd0, 1, 0, 0);
    xfer(16'h8001, 32'h0000_2000, 1, 2'd1, 1, 40, 0);
    xfer(16'h00FF, 32'h0000_3000, 0, 2'd2, 0, 0, 0);
    xfer(16'hFFFF, 32'h0000_4000, 1, 2'd3, 1, 30, 0);
    xfer(16'h000F, 32'h0000_0008, 0, 2'd3, 1, 50, 0);   // wraps below zero
    xfer(16'h0001, 32'hFFFF_FFFC, 1, 2'd1, 1, 0, 0);    // wraps above top
    phase = "R8";
    for (int m = 0; m < 4; m++) xfer(16'h0000, 32'h0000_5000 + 32'(m), 1'(m), 2'(m), 1, 0, 0);
    phase = "R9";
    xfer(16'h0A0A, 32'h0000_6000, 1, 2'd0, 1, 50, 1);
    xfer(16'h3003, 32'h0000_7000, 0, 2'd2, 1, 60, 1);
    phase = "R2";
    for (int k = 0; k < 40; k++)
      xfer(16'($urandom()), $urandom(), 1'($urandom()), 2'($urandom()), 1'($urandom()),
           int'($urandom_range(60)), 1'($urandom()));
    // back-to-back reset mid-transfer
    start = 1; reg_mask = 16'h00F0; base_in = 32'h100; mode = 0; mem_ready = 0;
    @(negedge clk);
    start = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule